// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block inspects one 16-bit instruction word and decides whether it is a conditional relative jump, whether that jump is taken under the current status flags, and what the program counter becomes next. The word's top four bits pick one of fifteen conditions, and a three-bit direction field selects forward or backward. The low six bits hold an unsigned distance that is added to or subtracted from the address after the current one.

Detection, condition evaluation and the target computation are purely combinational. They use the instruction word, the current program counter and five flag inputs (negative, zero, sign, carry, overflow). A program-counter register inside the block loads the computed next address on every clock edge where the step enable is high. Fetching, far transfers that need a second word, ALU execution and interrupt control belong to other blocks.

Top module: `rel_branch_unit`

## Requirements
- R1: `jumpHit` is 1 exactly when bits 11:9 of the word are 000 and bits 15:12 are not 1111.
- R2: A word with bits 15:12 equal to 1111 never raises `jumpHit` or `jumpTaken`, and its `nextPc` is `curPc`+1.
- R3: For a legal jump word, bits 15:12 select the condition for `jumpTaken`: 0 carry clear, 1 carry set, 2 sign clear, 3 sign set, 4 zero clear, 5 zero set, 6 negative clear, 7 negative set, C overflow clear, D overflow set, E always.
- R4: Code 8 is taken when carry is clear or zero is set, and code 9 is taken in exactly the other cases. Code A is taken when sign is set or zero is set, and code B is taken in exactly the other cases.
- R5: A jump word whose bits 8:6 are neither 000 nor 001 raises `jumpIllegal`, is never taken, and gives `nextPc` = `curPc`+1. No other word raises `jumpIllegal`.
- R6: When bits 8:6 are 000, `targetAddr` = `curPc`+1+imm, where imm is bits 5:0 taken as unsigned, modulo 2^16.
- R7: When bits 8:6 are 001, `targetAddr` = `curPc`+1−imm, modulo 2^16.
- R8: `nextPc` equals `targetAddr` when `jumpTaken` is 1, and equals `curPc`+1 (modulo 2^16) otherwise.
- R9: `pcQ` is 0 during and after reset. At each rising clock edge it takes `nextPc` if `stepEn` is 1, and keeps its value if `stepEn` is 0.
- R10: A word with nonzero bits 11:9 is not a jump. It is never taken and gives `nextPc` = `curPc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Load `nextPc` into `pcQ` at this edge |
| instrWord | input | 16 | Instruction word under test |
| curPc | input | 16 | Address of the instruction word |
| flagNeg | input | 1 | Negative flag |
| flagZero | input | 1 | Zero flag |
| flagSign | input | 1 | Sign flag |
| flagCarry | input | 1 | Carry flag |
| flagOvf | input | 1 | Overflow flag |
| jumpHit | output | 1 | Word is a relative jump |
| jumpTaken | output | 1 | Jump is taken |
| jumpIllegal | output | 1 | Jump word with an unusable direction code |
| targetAddr | output | 16 | Branch destination |
| nextPc | output | 16 | Address to continue from |
| pcQ | output | 16 | Registered program counter |

## Verification
`jumpHit`, `jumpTaken`, `jumpIllegal`, `targetAddr` and `nextPc` settle in the same cycle as their inputs. The bench drives every input on the falling edge and samples these outputs 2 ns later, well before the next rising edge. `pcQ` changes one rising edge after the stimulus. It is therefore checked at the following falling edge, before new inputs go in, against the `nextPc` value the reference model predicted for the previous vector, or against the held value when `stepEn` was low.

// File: rtl/rbu_pkg.sv
`timescale 1ns/1ps
package rbu_pkg;

  localparam int INSTR_W  = 16;
  localparam int IMM_W    = 6;
  localparam int OPC1_LSB = 6;
  localparam int OPA_LSB  = 9;
  localparam int OPC0_LSB = 12;
  localparam int CTRL_W   = INSTR_W - IMM_W;

  // Conditions come in complementary pairs: odd code = inverse of the even one.
  typedef enum logic [3:0] {
    CC_CARRY_CLR = 4'h0, CC_CARRY_SET = 4'h1,
    CC_SIGN_CLR  = 4'h2, CC_SIGN_SET  = 4'h3,
    CC_NONZERO   = 4'h4, CC_ZERO      = 4'h5,
    CC_PLUS      = 4'h6, CC_MINUS     = 4'h7,
    CC_BELOW_EQ  = 4'h8, CC_ABOVE     = 4'h9,
    CC_LESS_EQ   = 4'hA, CC_GREATER   = 4'hB,
    CC_OVF_CLR   = 4'hC, CC_OVF_SET   = 4'hD,
    CC_ALWAYS    = 4'hE, CC_SPECIAL   = 4'hF
  } condCode_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } flagSet_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic jumpHit;
    logic jumpTaken;
    logic jumpIllegal;
    logic goBack;
  } brStrobe_t;

endpackage

// File: rtl/rbu_ctrl.sv
`timescale 1ns/1ps
module rbu_ctrl
  import rbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlBits,
  input  flagSet_t          flags,
  output brStrobe_t         strobe
);

  localparam int NUM_PAIRS = 8;
  localparam int SEL_W     = $clog2(NUM_PAIRS);
  localparam int C0_LO     = OPC0_LSB - IMM_W;
  localparam int CA_LO     = OPA_LSB - IMM_W;
  localparam int C1_LO     = OPC1_LSB - IMM_W;

  condCode_e            cc;
  logic [2:0]           opA;
  logic [2:0]           opc1;
  logic [NUM_PAIRS-1:0] pairBase;
  logic [SEL_W-1:0]     pairSel;
  logic                 condMet;
  logic                 isJump;
  logic                 dirLegal;

  assign cc      = condCode_e'(ctrlBits[C0_LO +: 4]);
  assign opA     = ctrlBits[CA_LO +: 3];
  assign opc1    = ctrlBits[C1_LO +: 3];
  assign pairSel = ctrlBits[C0_LO + 1 +: SEL_W];

  // Base (even-code) condition of each pair; odd code inverts it.
  always_comb begin
    pairBase[0] = !flags.carry;
    pairBase[1] = !flags.sign;
    pairBase[2] = !flags.zero;
    pairBase[3] = !flags.neg;
    pairBase[4] = !flags.carry || flags.zero;
    pairBase[5] = flags.sign || flags.zero;
    pairBase[6] = !flags.ovf;
    pairBase[7] = 1'b1;
  end

  always_comb begin
    condMet  = pairBase[pairSel] ^ cc[0];
    isJump   = (opA == 3'd0) && (cc != CC_SPECIAL);
    dirLegal = (opc1[2:1] == 2'b00);
    strobe.jumpHit     = isJump;
    strobe.jumpIllegal = isJump && !dirLegal;
    strobe.jumpTaken   = isJump && dirLegal && condMet;
    strobe.goBack      = opc1[0];
  end

  a_r2_special_never_jumps: assert property (@(posedge clk) disable iff (!rstN)
    (cc == CC_SPECIAL) |-> (!strobe.jumpHit && !strobe.jumpTaken));

  a_r10_nonzero_opa_not_jump: assert property (@(posedge clk) disable iff (!rstN)
    (opA != 3'd0) |-> !strobe.jumpHit);

  a_r5_illegal_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jumpIllegal |-> !strobe.jumpTaken);

  a_r3_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.jumpHit && cc == CC_ALWAYS && opc1 == 3'd0) |-> strobe.jumpTaken);

endmodule

// File: rtl/rbu_dpath.sv
`timescale 1ns/1ps
module rbu_dpath
  import rbu_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [IMM_W-1:0]  imm,
  input  brStrobe_t         strobe,
  output logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] pcQ
);

  localparam int PAD_W = ADDR_W - IMM_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pcPlusOne;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] fwdAddr;
  logic [ADDR_W-1:0] backAddr;

  always_comb begin
    pcPlusOne  = curPc + ONE;
    offset     = {{PAD_W{1'b0}}, imm};
    fwdAddr    = pcPlusOne + offset;
    backAddr   = pcPlusOne - offset;
    targetAddr = strobe.goBack ? backAddr : fwdAddr;
    nextPc     = strobe.jumpTaken ? targetAddr : pcPlusOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pcQ <= RESET_PC;
    else if (stepEn) pcQ <= nextPc;
  end

  a_r1_taken_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jumpTaken |-> strobe.jumpHit);

  a_r5_illegal_falls_through: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jumpIllegal |-> (nextPc - curPc) == ONE);

  a_r8_untaken_sequential: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.jumpTaken |-> (nextPc - curPc) == ONE);

  a_r9_pc_loads: assert property (@(posedge clk) disable iff (!rstN)
    stepEn |=> pcQ == $past(nextPc));

  a_r9_pc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(pcQ));

endmodule

// File: rtl/rel_branch_unit.sv
`timescale 1ns/1ps
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepEn,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  curPc,
  input  logic               flagNeg,
  input  logic               flagZero,
  input  logic               flagSign,
  input  logic               flagCarry,
  input  logic               flagOvf,
  output logic               jumpHit,
  output logic               jumpTaken,
  output logic               jumpIllegal,
  output logic [ADDR_W-1:0]  targetAddr,
  output logic [ADDR_W-1:0]  nextPc,
  output logic [ADDR_W-1:0]  pcQ
);

  brStrobe_t strobe;
  flagSet_t  flags;

  assign flags = '{neg: flagNeg, zero: flagZero, sign: flagSign,
                   carry: flagCarry, ovf: flagOvf};

  rbu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBits (instrWord[INSTR_W-1:IMM_W]),
    .flags    (flags),
    .strobe   (strobe)
  );

  rbu_dpath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .curPc      (curPc),
    .imm        (instrWord[IMM_W-1:0]),
    .strobe     (strobe),
    .targetAddr (targetAddr),
    .nextPc     (nextPc),
    .pcQ        (pcQ)
  );

  assign jumpHit     = strobe.jumpHit;
  assign jumpTaken   = strobe.jumpTaken;
  assign jumpIllegal = strobe.jumpIllegal;

endmodule

// File: tb/rel_branch_unit_tb.sv
`timescale 1ns/1ps
module rel_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] curPc = '0;
  logic        flagNeg = 1'b0, flagZero = 1'b0, flagSign = 1'b0;
  logic        flagCarry = 1'b0, flagOvf = 1'b0;
  logic        jumpHit, jumpTaken, jumpIllegal;
  logic [15:0] targetAddr, nextPc, pcQ;

  int  nChecks = 0;
  int  nFail = 0;
  bit  havePrev = 0;
  logic [15:0] prevPcExp = '0;
  bit  finished = 0;

  always #10 clk = ~clk;

  rel_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .instrWord(instrWord), .curPc(curPc),
    .flagNeg(flagNeg), .flagZero(flagZero), .flagSign(flagSign),
    .flagCarry(flagCarry), .flagOvf(flagOvf),
    .jumpHit(jumpHit), .jumpTaken(jumpTaken), .jumpIllegal(jumpIllegal),
    .targetAddr(targetAddr), .nextPc(nextPc), .pcQ(pcQ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural condition table (bits 15:12 of the word).
  function automatic bit condHolds(int code, bit n, bit z, bit s, bit c, bit v);
    case (code)
      0:  return !c;
      1:  return c;
      2:  return !s;
      3:  return s;
      4:  return !z;
      5:  return z;
      6:  return !n;
      7:  return n;
      8:  return !c || z;
      9:  return c && !z;
      10: return s || z;
      11: return !s && !z;
      12: return !v;
      13: return v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [15:0] word, input logic [15:0] pc,
                       input logic [4:0] f, input bit step);
    int opc, opA, op1;
    logic [15:0] imm, pc1, eTgt, eNext;
    bit eHit, eIll, eTaken;
    string tTag;
    @(negedge clk);
    if (havePrev) chk("R9 pcQ after edge", pcQ, prevPcExp);
    instrWord = word; curPc = pc; stepEn = step;
    {flagNeg, flagZero, flagSign, flagCarry, flagOvf} = f;
    #2;
    opc = int'(word[15:12]); opA = int'(word[11:9]); op1 = int'(word[8:6]);
    imm = {10'd0, word[5:0]};
    eHit   = (opA == 0) && (opc != 15);
    eIll   = eHit && (op1 > 1);
    eTaken = eHit && !eIll && condHolds(opc, f[4], f[3], f[2], f[1], f[0]);
    pc1    = pc + 16'd1;
    eTgt   = (op1 == 1) ? pc1 - imm : pc1 + imm;
    eNext  = eTaken ? eTgt : pc1;
    chk(opc == 15 ? "R2 jumpHit" : (opA != 0 ? "R10 jumpHit" : "R1 jumpHit"),
        {31'd0, jumpHit}, {31'd0, eHit});
    if (eIll)                        tTag = "R5 jumpTaken";
    else if (opA != 0)               tTag = "R10 jumpTaken";
    else if (opc == 15)              tTag = "R2 jumpTaken";
    else if (opc >= 8 && opc <= 11)  tTag = "R4 jumpTaken";
    else                             tTag = "R3 jumpTaken";
    chk(tTag, {31'd0, jumpTaken}, {31'd0, eTaken});
    chk("R5 jumpIllegal", {31'd0, jumpIllegal}, {31'd0, eIll});
    if (eHit && !eIll)
      chk(op1 == 1 ? "R7 targetAddr" : "R6 targetAddr", {16'd0, targetAddr}, {16'd0, eTgt});
    chk("R8 nextPc", {16'd0, nextPc}, {16'd0, eNext});
    prevPcExp = step ? eNext : pcQ;
    havePrev  = 1;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] pcList [4];
    pcList[0] = 16'hFFC0; pcList[1] = 16'hFFFF; pcList[2] = 16'h0000; pcList[3] = 16'h0020;
    repeat (3) @(negedge clk);
    chk("R9 pcQ in reset", {16'd0, pcQ}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 pcQ after reset", {16'd0, pcQ}, 32'd0);

    // Hold: taken jump presented with stepEn low must not move pcQ.
    drive(16'hE005, 16'h1234, 5'b00000, 1'b0);
    drive(16'hE03F, 16'hFFFF, 5'b11111, 1'b0);

    // Full sweep: every code, every flag combination, both directions,
    // extreme distances, addresses around the wrap point.
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 32; f++)
        for (int dir = 0; dir < 2; dir++)
          for (int oi = 0; oi < 2; oi++)
            for (int pi = 0; pi < 4; pi++)
              drive({cc[3:0], 3'd0, dir[2:0], (oi == 0) ? 6'd0 : 6'd63},
                    pcList[pi], f[4:0], 1'b1);

    // Nonzero operand A field: never a jump.
    for (int a = 1; a < 8; a++)
      for (int cc = 0; cc < 16; cc++)
        drive({cc[3:0], a[2:0], 3'd0, 6'd17}, 16'hFFFE, 5'b01010, 1'b1);

    // Unusable direction codes on jump words, including the always code.
    for (int d = 2; d < 8; d++)
      for (int cc = 0; cc < 15; cc++)
        drive({cc[3:0], 3'd0, d[2:0], 6'd9}, 16'h7FFF, 5'b10101, 1'b1);

    // Interleave steps and holds.
    drive(16'hE07F, 16'h0003, 5'b00000, 1'b1);
    drive(16'h5011, 16'h0100, 5'b01000, 1'b0);
    drive(16'h5011, 16'h0100, 5'b00000, 1'b1);

    @(negedge clk);
    chk("R9 pcQ final", {16'd0, pcQ}, {16'd0, prevPcExp});
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule